// File: doc/BRIEF.md
# Overlapped Instruction Fetch Sequencer

This block is the front end of a small processor core with separate program and data memories. It holds the program counter and drives the address of a 14-bit program memory read port. It captures each returned word into an instruction register, which the execute stage consumes. The next word is fetched while the current one executes, so a straight-line instruction takes one cycle. The program memory answers one clock after it sees an address.

The flow of control can change in two ways. The execute stage can signal a taken branch with a target address, or an ordinary data-side write can land on the program counter, which is visible in the data address space. In either case the word already in flight is discarded and a single bubble appears on the instruction register, so a redirect costs two cycles in total. The program space holds 1024, 2048 or 4096 words, chosen by a parameter, and the counter wraps from the last word to zero.

A three-state controller runs the sequence. BOOT is the state after reset: it presents the counter itself, which is zero. FILL is a cycle in which the instruction register holds nothing valid and the next sequential address is presented. EXEC is the state in which the instruction register is valid. The transitions are: BOOT to FILL, always; FILL to EXEC, always; EXEC to FILL, on a redirect; EXEC to EXEC, otherwise.

Top module: `fetch_seq`

## Requirements
- R1: While reset (rst_n low, asynchronous) is asserted, ir_valid is 0, pm_addr is 0 and ir_word is 0.
- R2: After reset is released, pm_addr is 0 in the first cycle and 1 in the second cycle. ir_valid stays 0 in both of those cycles and becomes 1 in the third cycle, with ir_addr 0.
- R3: While ir_valid is 1 and no redirect is requested, ir_addr advances by one in the next cycle and ir_valid stays 1. In the current cycle pm_addr equals ir_addr plus two, modulo the program size.
- R4: Whenever ir_valid is 1, ir_word equals the pm_rdata value of the previous cycle. That value is the memory word at ir_addr.
- R5: A branch (br_take high while ir_valid is 1) places br_target on pm_addr in the same cycle. ir_valid is 0 in the next cycle, and in the cycle after that ir_valid is 1 with ir_addr equal to br_target.
- R6: A program counter write (pcw_en high while ir_valid is 1) redirects fetch to pcw_data with the same one-bubble timing as R5.
- R7: When br_take and pcw_en are both high, br_target wins and pcw_data is ignored.
- R8: While ir_valid is 0, br_take and pcw_en have no effect. pm_addr and the following ir_addr continue the sequential order.
- R9: Sequential fetch wraps from address PROG_WORDS-1 to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pm_addr | output | AW = log2(PROG_WORDS) | Program memory read address |
| pm_rdata | input | 14 | Program memory read data, valid one clock after its address |
| ir_word | output | 14 | Instruction register contents |
| ir_valid | output | 1 | Instruction register holds a word to execute |
| ir_addr | output | AW | Program address of the word in the instruction register |
| br_take | input | 1 | Taken branch from the execute stage |
| br_target | input | AW | Branch target address |
| pcw_en | input | 1 | Data-side write to the program counter |
| pcw_data | input | AW | Value written to the program counter |

## Verification
Several properties are checked on every cycle: the reset values, the sequential address step, the link between ir_word and the previous pm_rdata, the single bubble after every redirect, and the address presented for a branch or a counter write, including the priority between them. Other behaviours appear only in the bench's scenarios, because they span several cycles or depend on what the inputs would have done. These include the exact start-up sequence, redirects that are ignored during a bubble, the wrap from the last word, and recovery after a reset in the middle of a run.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
    typedef enum logic [1:0] {
        S_BOOT = 2'd0,
        S_FILL = 2'd1,
        S_EXEC = 2'd2
    } fseq_state_e;
endpackage

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
    import fseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        br_take,
    input  logic        pcw_en,
    output fseq_state_e state,
    output logic        redirect,
    output logic        ir_valid,
    output logic        ir_load
);
    fseq_state_e state_nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_BOOT;
        else        state <= state_nxt;
    end

    // transitions and outputs
    always_comb begin
        redirect  = 1'b0;
        ir_valid  = 1'b0;
        ir_load   = 1'b1;
        state_nxt = state;
        unique case (state)
            S_BOOT: begin
                ir_load   = 1'b0;
                state_nxt = S_FILL;
            end
            S_FILL: begin
                state_nxt = S_EXEC;
            end
            S_EXEC: begin
                ir_valid  = 1'b1;
                redirect  = br_take | pcw_en;
                state_nxt = (br_take | pcw_en) ? S_FILL : S_EXEC;
            end
            default: begin
                ir_load   = 1'b0;
                state_nxt = S_BOOT;
            end
        endcase
    end
endmodule

// File: rtl/fseq_pc.sv
module fseq_pc
    import fseq_pkg::*;
#(
    parameter int PROG_WORDS = 1024,
    parameter int AW         = $clog2(PROG_WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  fseq_state_e   state,
    input  logic          redirect,
    input  logic          br_take,
    input  logic [AW-1:0] br_target,
    input  logic [AW-1:0] pcw_data,
    output logic [AW-1:0] pm_addr,
    output logic [AW-1:0] pc
);
    localparam logic [AW-1:0] LAST_WORD = AW'(PROG_WORDS - 1);

    logic [AW-1:0] seq_addr;
    logic [AW-1:0] jump_addr;

    always_comb begin
        seq_addr  = (pc == LAST_WORD) ? '0 : pc + AW'(1);
        jump_addr = br_take ? br_target : pcw_data;
        unique case (state)
            S_BOOT:  pm_addr = pc;
            S_FILL:  pm_addr = seq_addr;
            S_EXEC:  pm_addr = redirect ? jump_addr : seq_addr;
            default: pm_addr = pc;
        endcase
    end

    // pc always holds the address whose word is arriving on the read port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc <= '0;
        else        pc <= pm_addr;
    end
endmodule

// File: rtl/fseq_ir.sv
module fseq_ir #(
    parameter int IW = 14,
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [IW-1:0] pm_rdata,
    input  logic [AW-1:0] pc,
    output logic [IW-1:0] ir_word,
    output logic [AW-1:0] ir_addr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ir_word <= '0;
            ir_addr <= '0;
        end else if (load) begin
            ir_word <= pm_rdata;
            ir_addr <= pc;
        end
    end
endmodule

// File: rtl/fetch_seq.sv
module fetch_seq
    import fseq_pkg::*;
#(
    parameter int PROG_WORDS = 1024,
    parameter int IW         = 14,
    parameter int AW         = $clog2(PROG_WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] pm_addr,
    input  logic [IW-1:0] pm_rdata,
    output logic [IW-1:0] ir_word,
    output logic          ir_valid,
    output logic [AW-1:0] ir_addr,
    input  logic          br_take,
    input  logic [AW-1:0] br_target,
    input  logic          pcw_en,
    input  logic [AW-1:0] pcw_data
);
    fseq_state_e   state;
    logic          redirect;
    logic          ir_load;
    logic [AW-1:0] pc;

    fseq_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .br_take  (br_take),
        .pcw_en   (pcw_en),
        .state    (state),
        .redirect (redirect),
        .ir_valid (ir_valid),
        .ir_load  (ir_load)
    );

    fseq_pc #(.PROG_WORDS(PROG_WORDS), .AW(AW)) u_pc (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .redirect  (redirect),
        .br_take   (br_take),
        .br_target (br_target),
        .pcw_data  (pcw_data),
        .pm_addr   (pm_addr),
        .pc        (pc)
    );

    fseq_ir #(.IW(IW), .AW(AW)) u_ir (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ir_load),
        .pm_rdata (pm_rdata),
        .pc       (pc),
        .ir_word  (ir_word),
        .ir_addr  (ir_addr)
    );
endmodule

// File: rtl/fseq_chk.sv
module fseq_chk #(
    parameter int IW = 14,
    parameter int AW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] pm_addr,
    input logic [IW-1:0] pm_rdata,
    input logic [IW-1:0] ir_word,
    input logic          ir_valid,
    input logic [AW-1:0] ir_addr,
    input logic          br_take,
    input logic [AW-1:0] br_target,
    input logic          pcw_en,
    input logic [AW-1:0] pcw_data
);
    logic redir_req;
    assign redir_req = ir_valid & (br_take | pcw_en);

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |-> (!ir_valid && pm_addr == '0 && ir_word == '0));

    p_seq_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_valid && !redir_req) |=> (ir_valid && ir_addr == AW'($past(ir_addr) + AW'(1))));

    p_seq_lookahead_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_valid && !redir_req) |-> (pm_addr == AW'(ir_addr + AW'(2))));

    p_word_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ir_valid |-> (ir_word == $past(pm_rdata)));

    p_branch_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_valid && br_take) |-> (pm_addr == br_target));

    p_bubble_r5: assert property (@(posedge clk) disable iff (!rst_n)
        redir_req |=> !ir_valid);

    p_pcw_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_valid && pcw_en && !br_take) |-> (pm_addr == pcw_data));

    p_bubble_refill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ir_valid && $past(ir_valid)) |=> ir_valid);
endmodule

bind fetch_seq fseq_chk #(.IW(IW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pm_addr   (pm_addr),
    .pm_rdata  (pm_rdata),
    .ir_word   (ir_word),
    .ir_valid  (ir_valid),
    .ir_addr   (ir_addr),
    .br_take   (br_take),
    .br_target (br_target),
    .pcw_en    (pcw_en),
    .pcw_data  (pcw_data)
);

// File: tb/fetch_seq_tb.sv
module fetch_seq_tb;
    localparam int WORDS = 1024;
    localparam int AW    = 10;
    localparam int IW    = 14;

    typedef struct packed {
        logic [3:0]    req;
        logic          br;
        logic [AW-1:0] tgt;
        logic          pcw;
        logic [AW-1:0] pdat;
        logic          ev;
        logic [AW-1:0] ea;
        logic [AW-1:0] epm;
    } vec_t;

    // req, br, tgt, pcw, pdat, exp valid, exp ir_addr, exp pm_addr
    localparam vec_t VEC [18] = '{
        '{4'd2, 1'b0, 10'd0,   1'b0, 10'd0,    1'b0, 10'd0,    10'd0},    // R2 BOOT
        '{4'd2, 1'b0, 10'd0,   1'b0, 10'd0,    1'b0, 10'd0,    10'd1},    // R2 FILL
        '{4'd2, 1'b0, 10'd0,   1'b0, 10'd0,    1'b1, 10'd0,    10'd2},    // R2 first word
        '{4'd5, 1'b1, 10'd100, 1'b0, 10'd0,    1'b1, 10'd1,    10'd100},  // R5 branch
        '{4'd8, 1'b1, 10'd5,   1'b0, 10'd0,    1'b0, 10'd0,    10'd101},  // R8 branch in bubble
        '{4'd8, 1'b0, 10'd0,   1'b0, 10'd0,    1'b1, 10'd100,  10'd102},  // R8 target kept
        '{4'd6, 1'b0, 10'd0,   1'b1, 10'd1023, 1'b1, 10'd101,  10'd1023}, // R6 pc write
        '{4'd9, 1'b0, 10'd0,   1'b0, 10'd0,    1'b0, 10'd0,    10'd0},    // R9 wrap on fetch
        '{4'd9, 1'b0, 10'd0,   1'b0, 10'd0,    1'b1, 10'd1023, 10'd1},    // R9 last word
        '{4'd7, 1'b1, 10'd7,   1'b1, 10'd200,  1'b1, 10'd0,    10'd7},    // R7 both asserted
        '{4'd8, 1'b0, 10'd0,   1'b1, 10'd300,  1'b0, 10'd0,    10'd8},    // R8 write in bubble
        '{4'd7, 1'b0, 10'd0,   1'b0, 10'd0,    1'b1, 10'd7,    10'd9},    // R7 branch won
        '{4'd6, 1'b0, 10'd0,   1'b1, 10'd50,   1'b1, 10'd8,    10'd50},   // R6 pc write
        '{4'd6, 1'b0, 10'd0,   1'b0, 10'd0,    1'b0, 10'd0,    10'd51},   // R6 bubble
        '{4'd5, 1'b1, 10'd51,  1'b0, 10'd0,    1'b1, 10'd50,   10'd51},   // R5 branch to next
        '{4'd5, 1'b0, 10'd0,   1'b0, 10'd0,    1'b0, 10'd0,    10'd52},   // R5 bubble
        '{4'd5, 1'b0, 10'd0,   1'b0, 10'd0,    1'b1, 10'd51,   10'd53},   // R5 target
        '{4'd3, 1'b0, 10'd0,   1'b0, 10'd0,    1'b1, 10'd52,   10'd54}    // R3 sequential
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] pm_addr;
    logic [IW-1:0] pm_rdata;
    logic [IW-1:0] ir_word;
    logic          ir_valid;
    logic [AW-1:0] ir_addr;
    logic          br_take = 1'b0;
    logic [AW-1:0] br_target = '0;
    logic          pcw_en = 1'b0;
    logic [AW-1:0] pcw_data = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    function automatic logic [IW-1:0] word_at(input logic [AW-1:0] a);
        return IW'(int'(a) * 29 + 11) ^ 14'h2AB;
    endfunction

    // program memory model: one clock read latency
    always_ff @(posedge clk) pm_rdata <= word_at(pm_addr);

    fetch_seq #(.PROG_WORDS(WORDS), .IW(IW)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pm_addr   (pm_addr),
        .pm_rdata  (pm_rdata),
        .ir_word   (ir_word),
        .ir_valid  (ir_valid),
        .ir_addr   (ir_addr),
        .br_take   (br_take),
        .br_target (br_target),
        .pcw_en    (pcw_en),
        .pcw_data  (pcw_data)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "ir_valid", 32'(ir_valid), 32'd0);
        chk("R1", "pm_addr",  32'(pm_addr),  32'd0);
        chk("R1", "ir_word",  32'(ir_word),  32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < 18; i++) begin
            string rq;
            rq = $sformatf("R%0d", VEC[i].req);
            chk(rq, "ir_valid", 32'(ir_valid), 32'(VEC[i].ev));
            if (VEC[i].ev) begin
                chk(rq, "ir_addr", 32'(ir_addr), 32'(VEC[i].ea));
                chk("R4", "ir_word", 32'(ir_word), 32'(word_at(VEC[i].ea)));
            end
            br_take   = VEC[i].br;
            br_target = VEC[i].tgt;
            pcw_en    = VEC[i].pcw;
            pcw_data  = VEC[i].pdat;
            #1;
            chk(rq, "pm_addr", 32'(pm_addr), 32'(VEC[i].epm));
            @(negedge clk);
        end
        br_take = 1'b0;
        pcw_en  = 1'b0;

        // R1: asynchronous reset in the middle of a run
        rst_n = 1'b0;
        #1;
        chk("R1", "ir_valid mid-run", 32'(ir_valid), 32'd0);
        chk("R1", "pm_addr mid-run",  32'(pm_addr),  32'd0);
        chk("R1", "ir_word mid-run",  32'(ir_word),  32'd0);
        repeat (2) @(negedge clk);

        // R2: restart sequence after the second reset
        rst_n = 1'b1;
        #1;
        chk("R2", "restart pm_addr c0", 32'(pm_addr), 32'd0);
        chk("R2", "restart valid c0", 32'(ir_valid), 32'd0);
        @(negedge clk);
        chk("R2", "restart pm_addr c1", 32'(pm_addr), 32'd1);
        chk("R2", "restart valid c1", 32'(ir_valid), 32'd0);
        @(negedge clk);
        chk("R2", "restart valid c2", 32'(ir_valid), 32'd1);
        chk("R2", "restart ir_addr", 32'(ir_addr), 32'd0);
        chk("R4", "restart ir_word", 32'(ir_word), 32'(word_at('0)));

        // R3: run straight for several cycles
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            chk("R3", "straight ir_addr", 32'(ir_addr), 32'(k));
            chk("R3", "straight pm_addr", 32'(pm_addr), 32'(k + 2));
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule